// File: doc/BRIEF.md
# Port Overload Fault Supervisor

This block decides when a powered network port must lose its power. It receives digitised comparator flags from the analog front end: the port current is above the cut level, the current has passed the severe-fault level, and the die is over temperature. It also receives a one-millisecond tick and a request to turn the port on. From these it drives the enable of the pass device, a one-cycle fast-off strobe, a flashing indicator and a one-cycle request to restart detection.

An overload is tolerated for a bounded number of ticks. If it clears before that, the count starts again from zero. If it lasts the whole window, the port is switched off, the indicator flashes and a fixed back-off passes before detection is requested again. A severe fault causes an immediate one-cycle turn-off. The port then goes back to its timed current-limited state without clearing the overload count. Over-temperature overrides everything. While it lasts, every output stays low. Once it clears, the same back-off passes (indicator dark) before detection restarts.

States: `ST_IDLE` (port off, waiting for a request), `ST_POWERED` (gate on, overload timer live), `ST_FASTOFF` (one cycle, gate off, strobe high), `ST_BACKOFF` (post-overload wait, indicator flashing), `ST_THERMAL` (over-temperature hold), `ST_COOL` (post-thermal wait), `ST_RESTART` (one-cycle detection request). Transitions: `ST_IDLE`→`ST_POWERED` on request. `ST_POWERED`→`ST_FASTOFF` on a rising severe flag. `ST_FASTOFF`→`ST_POWERED` after one cycle. `ST_POWERED`/`ST_FASTOFF`→`ST_BACKOFF` on overload expiry. `ST_POWERED`/`ST_FASTOFF`→`ST_IDLE` when the request drops. `ST_BACKOFF`/`ST_COOL`→`ST_RESTART` when the wait expires. `ST_RESTART`→`ST_IDLE` after one cycle. Any state→`ST_THERMAL` on over-temperature. `ST_THERMAL`→`ST_COOL` when the flag clears.

Top module: `port_fault_supervisor`

## Requirements
- R1: After reset all four outputs are low and the block is idle with the gate off.
- R2: With the block idle, a high `port_on_req` drives `gate_en` high on the next clock edge. Dropping the request while the port is powered turns `gate_en` off on the next edge.
- R3: While the port is powered, each `ms_tick` with `over_cut` high advances the overload count. On the `EXPIRE_MS`-th such tick, taken with `over_cut` still high, `gate_en` goes low at that edge.
- R4: Any clock cycle with `over_cut` low while powered clears the overload count, so the port stays on and a full `EXPIRE_MS` further overload ticks are needed for a shutdown.
- R5: A rising edge of `severe_fault` on a powered port gives exactly one cycle of `fast_off` high with `gate_en` low, after which `gate_en` returns high. The overload count is kept across this cycle. A severe flag that stays high does not strobe again.
- R6: During the wait after an overload shutdown, `led_flash` is a square wave that starts high, changes level every `LED_HALF_MS` ticks, and is low in every other state.
- R7: The `WAIT_MS`-th tick of a post-fault wait produces a one-cycle `detect_restart` pulse. The block then goes idle, and a held request powers the port again two cycles after the pulse.
- R8: One edge after `over_temp` goes high, `gate_en`, `fast_off`, `led_flash` and `detect_restart` are all low, and they stay low while the flag stays high.
- R9: After `over_temp` clears, `WAIT_MS` ticks pass with all outputs low and the indicator dark, then a one-cycle `detect_restart` pulse follows.
- R10: Over-temperature wins over an overload expiry in the same cycle, and an overload expiry wins over a severe-fault edge in the same cycle (no strobe, wait entered).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| port_on_req | input | 1 | Request to power the port |
| over_cut | input | 1 | Port current above the cut level |
| severe_fault | input | 1 | Port current above the severe-fault level |
| over_temp | input | 1 | Die temperature above the trip point |
| gate_en | output | 1 | Enable of the port pass device |
| fast_off | output | 1 | One-cycle fast turn-off strobe |
| led_flash | output | 1 | Fault indicator, square wave during the overload wait |
| detect_restart | output | 1 | One-cycle request to restart detection |

## Verification
The bench builds the block with `EXPIRE_MS` = 6, `WAIT_MS` = 8 and `LED_HALF_MS` = 2, and produces the millisecond tick itself. These short windows let every expiry, every full back-off and two complete indicator periods be counted out tick by tick. The one-tick-early and exact-expiry boundaries become checkable without long runs. The same values let a severe-fault edge arrive partway through an overload window, so the test can show the count surviving the strobe. They also allow same-cycle collisions between expiry, severe fault and over-temperature to be set up directly.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_POWERED = 3'd1,
        ST_FASTOFF = 3'd2,
        ST_BACKOFF = 3'd3,
        ST_THERMAL = 3'd4,
        ST_COOL    = 3'd5,
        ST_RESTART = 3'd6
    } pfs_state_e;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/pfs_tick_timer.sv
module pfs_tick_timer #(
    parameter int unsigned LIMIT = 62
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic hit
);
    localparam int unsigned CW = pfs_pkg::cnt_width(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (adv && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit = adv && !clr && (cnt_q == LAST);

endmodule

// File: rtl/pfs_blinker.sv
module pfs_blinker #(
    parameter int unsigned HALF_TICKS = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    output logic led
);
    localparam int unsigned CW = pfs_pkg::cnt_width(HALF_TICKS);
    localparam logic [CW-1:0] LAST = CW'(HALF_TICKS - 1);

    logic [CW-1:0] half_q;
    logic          phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q  <= '0;
            phase_q <= 1'b0;
        end else if (!en) begin
            half_q  <= '0;
            phase_q <= 1'b0;
        end else if (tick) begin
            if (half_q == LAST) begin
                half_q  <= '0;
                phase_q <= ~phase_q;
            end else begin
                half_q <= half_q + 1'b1;
            end
        end
    end

    assign led = en && !phase_q;

endmodule

// File: rtl/port_fault_supervisor.sv
module port_fault_supervisor #(
    parameter int unsigned EXPIRE_MS   = 62,
    parameter int unsigned WAIT_MS     = 4000,
    parameter int unsigned LED_HALF_MS = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic port_on_req,
    input  logic over_cut,
    input  logic severe_fault,
    input  logic over_temp,
    output logic gate_en,
    output logic fast_off,
    output logic led_flash,
    output logic detect_restart
);
    import pfs_pkg::*;

    pfs_state_e state_q, state_d;
    logic       sev_q;
    logic       sev_rise;
    logic       live;
    logic       waiting;
    logic       ovl_clr, ovl_hit;
    logic       wait_hit;
    logic       blink_led;

    assign sev_rise = severe_fault && !sev_q;
    assign live     = (state_q == ST_POWERED) || (state_q == ST_FASTOFF);
    assign waiting  = (state_q == ST_BACKOFF) || (state_q == ST_COOL);
    assign ovl_clr  = !live || !over_cut;

    // overload window: consecutive ticks with current above the cut level
    pfs_tick_timer #(.LIMIT(EXPIRE_MS)) i_ovl_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ovl_clr),
        .adv   (ms_tick && over_cut),
        .hit   (ovl_hit)
    );

    // back-off before detection restarts
    pfs_tick_timer #(.LIMIT(WAIT_MS)) i_wait_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!waiting),
        .adv   (ms_tick),
        .hit   (wait_hit)
    );

    pfs_blinker #(.HALF_TICKS(LED_HALF_MS)) i_blinker (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state_q == ST_BACKOFF),
        .tick  (ms_tick),
        .led   (blink_led)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sev_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sev_q   <= severe_fault;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (over_temp)        state_d = ST_THERMAL;
                else if (port_on_req) state_d = ST_POWERED;
            end
            ST_POWERED: begin
                if (over_temp)         state_d = ST_THERMAL;
                else if (ovl_hit)      state_d = ST_BACKOFF;
                else if (sev_rise)     state_d = ST_FASTOFF;
                else if (!port_on_req) state_d = ST_IDLE;
            end
            ST_FASTOFF: begin
                if (over_temp)         state_d = ST_THERMAL;
                else if (ovl_hit)      state_d = ST_BACKOFF;
                else if (!port_on_req) state_d = ST_IDLE;
                else                   state_d = ST_POWERED;
            end
            ST_BACKOFF: begin
                if (over_temp)     state_d = ST_THERMAL;
                else if (wait_hit) state_d = ST_RESTART;
            end
            ST_THERMAL: begin
                if (!over_temp) state_d = ST_COOL;
            end
            ST_COOL: begin
                if (over_temp)     state_d = ST_THERMAL;
                else if (wait_hit) state_d = ST_RESTART;
            end
            ST_RESTART: begin
                if (over_temp) state_d = ST_THERMAL;
                else           state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        gate_en        = 1'b0;
        fast_off       = 1'b0;
        led_flash      = 1'b0;
        detect_restart = 1'b0;
        unique case (state_q)
            ST_POWERED: gate_en        = 1'b1;
            ST_FASTOFF: fast_off       = 1'b1;
            ST_BACKOFF: led_flash      = blink_led;
            ST_RESTART: detect_restart = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/pfs_checker.sv
module pfs_checker #(
    parameter int unsigned EXPIRE_MS = 62
) (
    input logic clk,
    input logic rst_n,
    input logic ms_tick,
    input logic port_on_req,
    input logic over_cut,
    input logic severe_fault,
    input logic over_temp,
    input logic gate_en,
    input logic fast_off,
    input logic led_flash,
    input logic detect_restart
);
    localparam int unsigned RW = $clog2(EXPIRE_MS + 2);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!(gate_en || fast_off) || !over_cut) begin
            run_q <= '0;
        end else if (ms_tick && (run_q != RW'(EXPIRE_MS + 1))) begin
            run_q <= run_q + 1'b1;
        end
    end

    assert_overload_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en |-> (run_q < RW'(EXPIRE_MS)));

    assert_strobe_gate_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fast_off |-> !gate_en);

    assert_strobe_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && $rose(severe_fault) && !over_temp && port_on_req && !ms_tick) |=> fast_off);

    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fast_off |=> !fast_off);

    assert_led_only_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        led_flash |-> (!gate_en && !fast_off && !detect_restart));

    assert_restart_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        detect_restart |=> !detect_restart);

    assert_thermal_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        over_temp |=> (!gate_en && !fast_off && !led_flash && !detect_restart));

endmodule

bind port_fault_supervisor pfs_checker #(.EXPIRE_MS(EXPIRE_MS)) i_pfs_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .ms_tick        (ms_tick),
    .port_on_req    (port_on_req),
    .over_cut       (over_cut),
    .severe_fault   (severe_fault),
    .over_temp      (over_temp),
    .gate_en        (gate_en),
    .fast_off       (fast_off),
    .led_flash      (led_flash),
    .detect_restart (detect_restart)
);

// File: tb/test_port_fault_supervisor.sv
module test_port_fault_supervisor;
    localparam int EXP  = 6;
    localparam int WT   = 8;
    localparam int HALF = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0, port_on_req = 1'b0, over_cut = 1'b0;
    logic severe_fault = 1'b0, over_temp = 1'b0;
    logic gate_en, fast_off, led_flash, detect_restart;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    port_fault_supervisor #(.EXPIRE_MS(EXP), .WAIT_MS(WT), .LED_HALF_MS(HALF)) i_port_fault_supervisor (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .port_on_req(port_on_req),
        .over_cut(over_cut), .severe_fault(severe_fault), .over_temp(over_temp),
        .gate_en(gate_en), .fast_off(fast_off), .led_flash(led_flash),
        .detect_restart(detect_restart)
    );

    task automatic check(input string req, input logic [3:0] exp_v);
        logic [3:0] act;
        act = {gate_en, fast_off, led_flash, detect_restart};
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s: {gate,fast,led,restart} actual=%b expected=%b", req, act, exp_v);
        end
    endtask

    task automatic tick();
        @(negedge clk) ms_tick = 1'b1;
        @(negedge clk) ms_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; port_on_req = 0; over_cut = 0; severe_fault = 0; over_temp = 0; ms_tick = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic power_up();
        port_on_req = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_reset_r1();
        do_reset();
        check("R1", 4'b0000);
    endtask

    task automatic test_on_off_r2();
        do_reset();
        port_on_req = 1'b1;
        check("R2 before edge", 4'b0000);
        @(negedge clk);
        check("R2 powered", 4'b1000);
        port_on_req = 1'b0;
        @(negedge clk);
        check("R2 request dropped", 4'b0000);
    endtask

    task automatic test_expiry_r3();
        do_reset();
        power_up();
        over_cut = 1'b1;
        ticks(EXP - 1);
        check("R3 one tick early", 4'b1000);
        tick();
        check("R3 expired", 4'b0010);
        over_cut = 1'b0;
    endtask

    task automatic test_clear_r4();
        do_reset();
        power_up();
        over_cut = 1'b1;
        ticks(EXP - 1);
        @(negedge clk) over_cut = 1'b0;
        @(negedge clk) over_cut = 1'b1;
        check("R4 still on after clear", 4'b1000);
        ticks(EXP - 1);
        check("R4 full window again", 4'b1000);
        tick();
        check("R4 expiry after full window", 4'b0010);
        over_cut = 1'b0;
    endtask

    task automatic test_severe_r5();
        do_reset();
        power_up();
        over_cut = 1'b1;
        ticks(3);
        @(negedge clk) severe_fault = 1'b1;
        @(negedge clk);
        check("R5 strobe", 4'b0100);
        @(negedge clk);
        check("R5 back to limited", 4'b1000);
        repeat (3) @(negedge clk);
        check("R5 no second strobe", 4'b1000);
        ticks(EXP - 4);
        check("R5 count kept", 4'b1000);
        tick();
        check("R5 expiry counts across strobe", 4'b0010);
        over_cut = 1'b0; severe_fault = 1'b0;
    endtask

    task automatic test_backoff_r6_r7();
        logic [3:0] e;
        do_reset();
        power_up();
        over_cut = 1'b1;
        ticks(EXP);
        over_cut = 1'b0;
        check("R6 led starts high", 4'b0010);
        for (int k = 1; k < WT; k++) begin
            tick();
            e = (((k / HALF) % 2) == 0) ? 4'b0010 : 4'b0000;
            check("R6 blink pattern", e);
        end
        tick();
        check("R7 restart pulse", 4'b0001);
        @(negedge clk);
        check("R7 idle after pulse", 4'b0000);
        @(negedge clk);
        check("R7 repowered", 4'b1000);
    endtask

    task automatic test_thermal_r8_r9();
        do_reset();
        power_up();
        over_temp = 1'b1;
        @(negedge clk);
        check("R8 gate removed", 4'b0000);
        ticks(WT + 2);
        check("R8 held quiet", 4'b0000);
        over_temp = 1'b0;
        @(negedge clk);
        ticks(WT - 1);
        check("R9 dark wait", 4'b0000);
        tick();
        check("R9 restart pulse", 4'b0001);
        @(negedge clk);
        check("R9 idle", 4'b0000);
        port_on_req = 1'b0;
    endtask

    task automatic test_priority_r10();
        do_reset();
        power_up();
        over_cut = 1'b1;
        ticks(EXP - 1);
        @(negedge clk) begin ms_tick = 1'b1; over_temp = 1'b1; end
        @(negedge clk) ms_tick = 1'b0;
        check("R10 thermal beats expiry", 4'b0000);
        over_temp = 1'b0; over_cut = 1'b0;
        do_reset();
        power_up();
        over_cut = 1'b1;
        ticks(EXP - 1);
        @(negedge clk) begin ms_tick = 1'b1; severe_fault = 1'b1; end
        @(negedge clk) ms_tick = 1'b0;
        check("R10 expiry beats severe", 4'b0010);
        over_cut = 1'b0; severe_fault = 1'b0;
    endtask

    initial begin
        #800000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        test_reset_r1();
        test_on_off_r2();
        test_expiry_r3();
        test_clear_r4();
        test_severe_r5();
        test_backoff_r6_r7();
        test_thermal_r8_r9();
        test_priority_r10();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule